// File: doc/BRIEF.md
# Edge-Selectable Latched Interrupt Request Register

This block holds a row of interrupt request bits, one per live status input. Each request bit watches its own status line and latches when that line changes in the direction the two global enables allow. A rising enable catches the moment a condition appears. A falling enable catches the moment it goes away. With both enables on, either change latches the bit. Once set, a bit stays set even if the status line returns to its old level.

A single interrupt line summarises the register. It is raised when at least one latched bit has its companion mask bit set. Software reads the register with a one-cycle read strobe. In that cycle the read data shows the latched bits, and the read clears every one of them at the next clock. An edge that arrives in the same cycle as the read is kept: its bit is set again, so no event is lost. The status, enable, mask and strobe pins are plain level signals with no handshake. The read data is a continuous view of the register and applies no back-pressure.

Top module: `edge_irq_reg`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `rd_data_o` is all zeros and `irq_o` is 0.
- R2: Each status bit is compared with its own value from the previous clock. When `rise_en_i`=1, a 0→1 change on a bit sets that request bit at the next clock edge. When `rise_en_i`=0, a 0→1 change is ignored.
- R3: When `fall_en_i`=1, a 1→0 change on a status bit sets that request bit at the next clock edge. When `fall_en_i`=0, a 1→0 change is ignored.
- R4: When both enables are 1, either direction of change sets the bit.
- R5: When both enables are 0, no status change sets any request bit.
- R6: A set request bit stays set, whatever its status input does, until a read clears it.
- R7: In a cycle with `rd_strobe_i`=1, `rd_data_o` shows the request bits as they stood before the clear. At the next clock edge all request bits are cleared, apart from bits covered by R8.
- R8: A qualifying edge in the same cycle as the read strobe leaves its bit set after that clock edge.
- R9: `irq_o` is registered and active-high. After each clock edge it equals the OR over all bits of (request bit AND the `mask_i` value sampled at that edge). A mask of all zeros therefore gives `irq_o`=0 at the next edge.
- R10: The level that the status inputs hold at the first clock after reset is taken as the baseline. That level is not an edge, even if it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| status_i | input | WIDTH | Live status conditions, one per request bit |
| rise_en_i | input | 1 | Global enable for setting bits on a 0→1 change |
| fall_en_i | input | 1 | Global enable for setting bits on a 1→0 change |
| mask_i | input | WIDTH | Per-bit interrupt enable, 1 = bit may raise `irq_o` |
| rd_strobe_i | input | 1 | One-cycle read; clears the register at the next edge |
| rd_data_o | output | WIDTH | Current request bits (pre-clear value during a read) |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
The hardest case to reach from the ports is an edge that lands in exactly the cycle of the clearing read. This must happen while other bits are being cleared, so that the result separates "kept" bits from "dropped" bits. The bench builds up several latched bits first. It then toggles one status line in the same cycle it raises the read strobe, once with the matching enable on and once with it off. A second hard case is a status level already high when reset is released. The bench holds all inputs high through reset to show that this level is taken as a baseline and not as an edge.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  localparam int unsigned DEF_WIDTH = 8;

  // Global edge selection shared by every bit of the register.
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_sel_t;

endpackage

// File: rtl/edge_irq_detect.sv
module edge_irq_detect
  import edge_irq_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  input  edge_sel_t        sel_i,
  output logic [WIDTH-1:0] hit_o
);

  logic [WIDTH-1:0] prev_q;
  logic             primed_q;

  // Baseline sample; the first post-reset cycle only loads it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= level_i;
      primed_q <= 1'b1;
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic up, down;
    assign up       = level_i[b] & ~prev_q[b];
    assign down     = ~level_i[b] & prev_q[b];
    assign hit_o[b] = primed_q & ((up & sel_i.rise) | (down & sel_i.fall));
  end

  AST_NO_EDGE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_i.rise && !sel_i.fall) |-> (hit_o == '0)); // R5

  AST_STEADY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(level_i) |-> (hit_o == '0)); // R2

endmodule

// File: rtl/edge_irq_latch.sv
module edge_irq_latch
  import edge_irq_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] req_o
);

  logic [WIDTH-1:0] req_q;

  // New events win over the clear so nothing is dropped at a read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= (clr_i ? '0 : req_q) | set_i;
  end

  assign req_o = req_q;

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i == '0) |=> (req_q == '0)); // R7

  AST_EDGE_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((req_q & $past(set_i)) == $past(set_i))); // R8

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && set_i == '0) |=> $stable(req_q)); // R6

endmodule

// File: rtl/edge_irq_reg.sv
module edge_irq_reg
  import edge_irq_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] status_i,
  input  logic             rise_en_i,
  input  logic             fall_en_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic             rd_strobe_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             irq_o
);

  edge_sel_t        sel;
  logic [WIDTH-1:0] hits;
  logic [WIDTH-1:0] req;
  logic [WIDTH-1:0] req_next;
  logic             irq_q;

  assign sel.rise = rise_en_i;
  assign sel.fall = fall_en_i;

  edge_irq_detect #(.WIDTH(WIDTH)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (status_i),
    .sel_i   (sel),
    .hit_o   (hits)
  );

  edge_irq_latch #(.WIDTH(WIDTH)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (hits),
    .clr_i (rd_strobe_i),
    .req_o (req)
  );

  // Interrupt tracks the register value it will hold after this edge.
  assign req_next = (rd_strobe_i ? '0 : req) | hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(req_next & mask_i);
  end

  assign rd_data_o = req;
  assign irq_o     = irq_q;

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '0) |=> !irq_o); // R9

  AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (rd_data_o != '0)); // R9

endmodule

// File: tb/tb_edge_irq_reg.sv
module tb_edge_irq_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] status_i = '0;
  logic         rise_en_i = 1'b0;
  logic         fall_en_i = 1'b0;
  logic [W-1:0] mask_i = '0;
  logic         rd_strobe_i = 1'b0;
  logic [W-1:0] rd_data_o;
  logic         irq_o;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  // Reference model state
  bit [W-1:0] m_req;
  bit [W-1:0] m_prev;
  bit         m_irq;
  bit         m_armed;

  always #5 clk = ~clk;

  edge_irq_reg #(.WIDTH(W)) dut (
    .clk, .rst_n, .status_i, .rise_en_i, .fall_en_i,
    .mask_i, .rd_strobe_i, .rd_data_o, .irq_o
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: advance the model at the edge, compare half a cycle later.
  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      m_req = '0; m_prev = '0; m_irq = 0; m_armed = 0;
    end else begin
      bit [W-1:0] s;
      s = '0;
      if (m_armed) begin
        for (int i = 0; i < W; i++) begin
          if (rise_en_i && status_i[i] && !m_prev[i]) s[i] = 1;
          if (fall_en_i && !status_i[i] && m_prev[i]) s[i] = 1;
        end
      end
      m_req = (rd_strobe_i ? '0 : m_req) | s;
      m_irq = |(m_req & mask_i);
      m_prev = status_i;
      m_armed = 1;
    end
    @(negedge clk);
    check({tag, " data"}, rd_data_o, m_req);
    check({tag, " irq"}, {{(W-1){1'b0}}, irq_o}, {{(W-1){1'b0}}, m_irq});
  endtask

  task automatic drive(logic [W-1:0] st, bit r, bit f, logic [W-1:0] mk, bit rd);
    status_i = st; rise_en_i = r; fall_en_i = f; mask_i = mk; rd_strobe_i = rd;
    step();
  endtask

  initial begin : watchdog
    #1ms;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 / R10: inputs all high through reset, baseline must not latch
    status_i = '1; rise_en_i = 1; fall_en_i = 1; mask_i = '1;
    tag = "R1";
    step(); step();
    check("R1 reset data", rd_data_o, '0);
    rst_n = 1'b1;
    step();
    check("R1 post-reset irq", {7'b0, irq_o}, 8'h00);
    tag = "R10";
    drive('1, 1, 1, '1, 0);
    drive('1, 1, 1, '1, 0);
    check("R10 baseline", rd_data_o, 8'h00);

    // R2: rise only
    tag = "R2";
    drive(8'h00, 1, 0, 8'h00, 0);       // falls ignored
    check("R2 fall ignored", rd_data_o, 8'h00);
    drive(8'h05, 1, 0, 8'h00, 0);
    check("R2 rise sets", rd_data_o, 8'h05);
    // R6: bit stays after status drops
    tag = "R6";
    drive(8'h00, 1, 0, 8'h00, 0);
    drive(8'h00, 1, 0, 8'h00, 0);
    check("R6 sticky", rd_data_o, 8'h05);
    // R9: mask enables irq
    tag = "R9";
    drive(8'h00, 1, 0, 8'h04, 0);
    check("R9 irq on", {7'b0, irq_o}, 8'h01);
    drive(8'h00, 1, 0, 8'h02, 0);
    check("R9 irq off", {7'b0, irq_o}, 8'h00);
    // R7: read returns pre-clear then clears
    tag = "R7";
    status_i = 8'h00; rd_strobe_i = 1; mask_i = '1;
    #1 check("R7 pre-clear view", rd_data_o, 8'h05);
    step();
    drive(8'h00, 1, 0, '1, 0);
    check("R7 cleared", rd_data_o, 8'h00);

    // R3: fall only
    tag = "R3";
    drive(8'hF0, 0, 1, '1, 0);
    check("R3 rise ignored", rd_data_o, 8'h00);
    drive(8'h30, 0, 1, '1, 0);
    check("R3 fall sets", rd_data_o, 8'hC0);
    drive(8'h30, 0, 1, '1, 1);

    // R4: both
    tag = "R4";
    drive(8'h0C, 1, 1, '1, 0);
    check("R4 both", rd_data_o, 8'h3C);
    drive(8'h0C, 1, 1, '1, 1);

    // R5: none enabled
    tag = "R5";
    drive(8'hF3, 0, 0, '1, 0);
    drive(8'h00, 0, 0, '1, 0);
    check("R5 no set", rd_data_o, 8'h00);

    // R8: edge in read cycle survives; disabled edge in read cycle drops
    tag = "R8";
    drive(8'h81, 1, 0, '1, 0);
    drive(8'h83, 1, 0, '1, 1);
    check("R8 kept", rd_data_o, 8'h02);
    drive(8'h83, 1, 0, '1, 0);
    drive(8'h87, 0, 1, '1, 1);
    check("R8 disabled dropped", rd_data_o, 8'h00);

    // Mixed patterns
    tag = "R4";
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] st, mk;
      st = W'($urandom);
      mk = W'($urandom);
      drive(st, 1'($urandom), 1'($urandom), mk, ($urandom % 5) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule